// File: doc/BRIEF.md
# Six-Channel Burst Arbiter

This block decides which of six DMA channels owns the shared bus. Each channel raises a request line while it has a burst to move. The arbiter grants one channel at a time. A grant lasts for exactly one burst, and the channel's engine ends it with a single-cycle `burst_done` strobe. Channels and bits are numbered 1 to 6 at the ports, and bit *i* of every channel vector belongs to channel *i+1*.

With `ch1_high_pri` clear, all six channels rotate fairly. The search for the next owner starts at the channel after the one served last and wraps from 6 back to 1. With `ch1_high_pri` set, a pending channel-1 request wins every decision, but it never cuts a burst short. If it takes the bus from another channel, the number of that channel is kept in `shadow_code`. When channel 1 lets go, the kept channel resumes ahead of the rotation.

A `prio_reset` pulse restarts the rotation at channel 1 and forgets the kept channel. Request/grant is a plain level handshake with no data stream, so there is no valid/ready pair and no back-pressure. A requester keeps its line high until it is granted.

Top module: `dma_burst_arbiter`

## Requirements
- R1: `grant` is one-hot or all zero. `active_code` equals the granted channel number (1..6), or 0 when `grant` is zero, and it never shows 7.
- R2: When the bus is idle and at least one request is high in a cycle, `grant` appears at the next rising edge, and only to a channel that was requesting in that cycle.
- R3: From the start of a burst until the cycle in which `burst_done` is high, `grant` holds its value and changes on `req` are ignored.
- R4: A decision is made in every cycle where the bus is idle or `burst_done` is high, and it takes effect at the next edge. If no request is high, `grant` and `active_code` become 0.
- R5: Without a channel-1 override or a resume, the next owner is the first requesting channel in the order last+1, last+2, … wrapping 6→1. The last-served channel itself is checked last.
- R6: With `ch1_high_pri` = 1, a decision in which `req[0]` is high grants channel 1, even when other channels are also requesting.
- R7: When channel 1 is granted under R6, `shadow_code` becomes the channel (2..6) that held the bus in the deciding cycle, or 0 if the bus was idle. If channel 1 itself held it, `shadow_code` keeps its value. `shadow_code` never shows 1 or 7.
- R8: At a decision that does not grant channel 1 under R6, a nonzero `shadow_code` whose channel is requesting wins over the rotation. Any grant other than channel 1 clears `shadow_code` to 0.
- R9: In a cycle with `prio_reset` high, the decision in that same cycle already searches from channel 1 and sees `shadow_code` as 0, and afterwards `shadow_code` is 0 unless R7 sets it. A burst in progress is not disturbed.
- R10: Asynchronous active-low reset clears `grant`, `active_code` and `shadow_code` to 0, and the first decision after reset searches from channel 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 6 | Burst request per channel, bit i = channel i+1 |
| burst_done | input | 1 | Strobe: the granted channel's burst ends this cycle |
| ch1_high_pri | input | 1 | 1: channel 1 overrides at each decision |
| prio_reset | input | 1 | Pulse: restart rotation at channel 1, forget kept channel |
| grant | output | 6 | One-hot bus grant, bit i = channel i+1 |
| active_code | output | 3 | Number of the granted channel, 0 when idle |
| shadow_code | output | 3 | Channel taken over by channel 1, 0 if none |

## Verification
A wrong rotation pointer stays hidden until the next decision. It then shows as a wrong `grant` one edge after the `burst_done` or idle request that triggers that decision, so the sequences include wrap-around and self-regrant cases that tell neighbouring pointer values apart. A wrong kept channel shows on `shadow_code` at once. It also shows one decision later as a missing or misdirected resume, and both are checked after each takeover. The `prio_reset` cases pick requests for which the rotation with and without the restart would grant different channels.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int DEF_NUM_CH = 6;

  typedef enum logic [2:0] {
    PICK_HOLD,
    PICK_IDLE,
    PICK_PRIO,
    PICK_RESUME,
    PICK_ROTATE
  } pick_kind_e;
endpackage

// File: rtl/dma_arb_rr_pick.sv
module dma_arb_rr_pick #(
  parameter int N  = 6,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] idx
);
  int cand;

  // Walk offsets from farthest to nearest so that the nearest requester
  // after 'last' is the one left in idx.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    cand  = 0;
    for (int off = N; off >= 1; off--) begin
      cand = int'(last) + off;
      if (cand >= N) cand = cand - N;
      if (req[cand]) begin
        found = 1'b1;
        idx   = IW'(cand);
      end
    end
  end
endmodule

// File: rtl/dma_arb_code_enc.sv
module dma_arb_code_enc #(
  parameter int N  = 6,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  onehot,
  output logic [CW-1:0] code
);
  always_comb begin
    code = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot[i]) code = code | CW'(i + 1);
    end
  end
endmodule

// File: rtl/dma_burst_arbiter.sv
module dma_burst_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = DEF_NUM_CH,
  parameter int IW     = $clog2(NUM_CH),
  parameter int CODE_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  input  logic              burst_done,
  input  logic              ch1_high_pri,
  input  logic              prio_reset,
  output logic [NUM_CH-1:0] grant,
  output logic [CODE_W-1:0] active_code,
  output logic [CODE_W-1:0] shadow_code
);
  localparam logic [IW-1:0]     LAST_INIT = IW'(NUM_CH - 1);
  localparam logic [NUM_CH-1:0] CH1_BIT   = NUM_CH'(1);

  logic [NUM_CH-1:0] grant_q, nxt_grant;
  logic [IW-1:0]     last_q, nxt_last, eff_last, rr_idx;
  logic [CODE_W-1:0] shadow_q, nxt_shadow, eff_shadow;
  logic              arb_slot, rr_found, shadow_hit;
  logic [NUM_CH-1:0] shadow_oh;
  pick_kind_e        kind;

  assign arb_slot   = (grant_q == '0) || burst_done;
  assign eff_last   = prio_reset ? LAST_INIT : last_q;
  assign eff_shadow = prio_reset ? '0 : shadow_q;

  dma_arb_rr_pick #(.N(NUM_CH), .IW(IW)) rr_i (
    .req   (req),
    .last  (eff_last),
    .found (rr_found),
    .idx   (rr_idx)
  );

  dma_arb_code_enc #(.N(NUM_CH), .CW(CODE_W)) enc_i (
    .onehot (grant_q),
    .code   (active_code)
  );

  // One-hot form of the kept channel, gated by its request.
  always_comb begin
    shadow_oh  = '0;
    shadow_hit = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (eff_shadow == CODE_W'(i + 1)) begin
        shadow_oh[i] = 1'b1;
        if (req[i]) shadow_hit = 1'b1;
      end
    end
  end

  // Decision priority: idle, channel-1 override, resume, rotation.
  always_comb begin
    kind = PICK_HOLD;
    if (arb_slot) begin
      if (req == '0)                      kind = PICK_IDLE;
      else if (ch1_high_pri && req[0])    kind = PICK_PRIO;
      else if (shadow_hit)                kind = PICK_RESUME;
      else if (rr_found)                  kind = PICK_ROTATE;
      else                                kind = PICK_IDLE;
    end
  end

  always_comb begin
    nxt_grant  = grant_q;
    nxt_last   = eff_last;
    nxt_shadow = eff_shadow;
    case (kind)
      PICK_IDLE: nxt_grant = '0;
      PICK_PRIO: begin
        nxt_grant  = CH1_BIT;
        nxt_last   = '0;
        nxt_shadow = (active_code == CODE_W'(1)) ? eff_shadow : active_code;
      end
      PICK_RESUME: begin
        nxt_grant  = shadow_oh;
        nxt_last   = IW'(eff_shadow - CODE_W'(1));
        nxt_shadow = '0;
      end
      PICK_ROTATE: begin
        nxt_grant  = CH1_BIT << rr_idx;
        nxt_last   = rr_idx;
        nxt_shadow = '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q  <= '0;
      last_q   <= LAST_INIT;
      shadow_q <= '0;
    end else begin
      grant_q  <= nxt_grant;
      last_q   <= nxt_last;
      shadow_q <= nxt_shadow;
    end
  end

  assign grant       = grant_q;
  assign shadow_code = shadow_q;

  // ---------------- assertions ----------------
  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_code_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    active_code <= CODE_W'(NUM_CH));

  assert_grant_requested_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arb_slot |=> ((grant & $past(req)) == grant));

  assert_grant_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && !burst_done) |=> $stable(grant));

  assert_idle_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_slot && req == '0) |=> (grant == '0 && active_code == '0));

  assert_ch1_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_slot && ch1_high_pri && req[0]) |=> grant[0]);

  assert_shadow_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_code != CODE_W'(1) && shadow_code <= CODE_W'(NUM_CH)));

  assert_shadow_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_slot && req != '0 && !(ch1_high_pri && req[0])) |=> shadow_code == '0);

  assert_prio_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_reset && !(arb_slot && ch1_high_pri && req[0])) |=> shadow_code == '0);
endmodule

// File: tb/dma_burst_arbiter_tb_top.sv
module dma_burst_arbiter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] req = '0;
  logic       burst_done = 1'b0;
  logic       ch1_high_pri = 1'b0;
  logic       prio_reset = 1'b0;
  logic [5:0] grant;
  logic [2:0] active_code;
  logic [2:0] shadow_code;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dma_burst_arbiter dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (req),
    .burst_done   (burst_done),
    .ch1_high_pri (ch1_high_pri),
    .prio_reset   (prio_reset),
    .grant        (grant),
    .active_code  (active_code),
    .shadow_code  (shadow_code)
  );

  // {rq, req, done, hi, prst, exp_grant, exp_shadow}
  localparam int NV = 32;
  localparam logic [21:0] VEC [NV] = '{
    {4'd2, 6'b001010, 3'b000, 6'b000010, 3'd0}, // 0  R2 idle -> ch2
    {4'd3, 6'b111111, 3'b000, 6'b000010, 3'd0}, // 1  R3 hold
    {4'd5, 6'b111111, 3'b100, 6'b000100, 3'd0}, // 2  R5 next after ch2
    {4'd5, 6'b000011, 3'b100, 6'b000001, 3'd0}, // 3  R5 wrap to ch1
    {4'd5, 6'b000001, 3'b100, 6'b000001, 3'd0}, // 4  R5 self last
    {4'd4, 6'b000000, 3'b100, 6'b000000, 3'd0}, // 5  R4 drop
    {4'd2, 6'b100000, 3'b000, 6'b100000, 3'd0}, // 6  R2 ch6
    {4'd5, 6'b100001, 3'b100, 6'b000001, 3'd0}, // 7  R5 6->1
    {4'd4, 6'b000000, 3'b100, 6'b000000, 3'd0}, // 8  R4
    {4'd6, 6'b001000, 3'b010, 6'b001000, 3'd0}, // 9  R6 ch4
    {4'd3, 6'b001001, 3'b010, 6'b001000, 3'd0}, // 10 R3 no mid-burst takeover
    {4'd7, 6'b001001, 3'b110, 6'b000001, 3'd4}, // 11 R7 ch1 takes ch4
    {4'd7, 6'b001001, 3'b110, 6'b000001, 3'd4}, // 12 R7 ch1 again keeps shadow
    {4'd8, 6'b011000, 3'b110, 6'b001000, 3'd0}, // 13 R8 resume ch4
    {4'd5, 6'b011000, 3'b110, 6'b010000, 3'd0}, // 14 R5 ch5
    {4'd7, 6'b000001, 3'b110, 6'b000001, 3'd5}, // 15 R7 takes ch5
    {4'd8, 6'b100000, 3'b110, 6'b100000, 3'd0}, // 16 R8 no resume, rotate
    {4'd4, 6'b000000, 3'b100, 6'b000000, 3'd0}, // 17 R4
    {4'd7, 6'b000001, 3'b010, 6'b000001, 3'd0}, // 18 R7 from idle -> 0
    {4'd4, 6'b000000, 3'b100, 6'b000000, 3'd0}, // 19 R4
    {4'd5, 6'b000100, 3'b000, 6'b000100, 3'd0}, // 20 R5 ch3
    {4'd5, 6'b000100, 3'b100, 6'b000100, 3'd0}, // 21 R5 self regrant
    {4'd9, 6'b001010, 3'b101, 6'b000010, 3'd0}, // 22 R9 restart -> ch2 not ch4
    {4'd4, 6'b000000, 3'b100, 6'b000000, 3'd0}, // 23 R4
    {4'd5, 6'b001000, 3'b010, 6'b001000, 3'd0}, // 24 R5 ch4
    {4'd7, 6'b001001, 3'b110, 6'b000001, 3'd4}, // 25 R7
    {4'd9, 6'b000001, 3'b011, 6'b000001, 3'd0}, // 26 R9 hold, shadow cleared
    {4'd9, 6'b001010, 3'b110, 6'b000010, 3'd0}, // 27 R9 no resume, ch2
    {4'd4, 6'b000000, 3'b100, 6'b000000, 3'd0}, // 28 R4
    {4'd5, 6'b010000, 3'b000, 6'b010000, 3'd0}, // 29 R5 ch5
    {4'd3, 6'b000000, 3'b000, 6'b010000, 3'd0}, // 30 R3 req drop ignored
    {4'd4, 6'b000000, 3'b100, 6'b000000, 3'd0}  // 31 R4
  };

  function automatic int code_of(input logic [5:0] g);
    int c = 0;
    for (int i = 0; i < 6; i++) if (g[i]) c = i + 1;
    return c;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a falling edge: drive, cross one rising edge, check.
  task automatic step(input logic [5:0] r, input logic d, input logic h,
                      input logic p, input logic [5:0] eg, input int esh,
                      input int rq, input int id);
    req = r; burst_done = d; ch1_high_pri = h; prio_reset = p;
    @(negedge clk);
    chk($sformatf("R%0d grant step %0d", rq, id), int'(grant), int'(eg));
    chk($sformatf("R1 active_code step %0d", id), int'(active_code), code_of(eg));
    chk($sformatf("R%0d shadow step %0d", rq, id), int'(shadow_code), esh);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 grant in reset", int'(grant), 0);
    chk("R10 active_code in reset", int'(active_code), 0);
    chk("R10 shadow in reset", int'(shadow_code), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      v = VEC[i];
      step(v[17:12], v[11], v[10], v[9], v[8:3], int'(v[2:0]), int'(v[21:18]), i);
    end

    // Directed: async reset mid-burst, then search restarts at ch1 (R10)
    step(6'b100000, 1'b0, 1'b0, 1'b0, 6'b100000, 0, 5, 100);
    rst_n = 1'b0;
    #2;
    chk("R10 grant after async reset", int'(grant), 0);
    chk("R10 active_code after async reset", int'(active_code), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(6'b111111, 1'b0, 1'b0, 1'b0, 6'b000001, 0, 10, 101);
    step(6'b000010, 1'b1, 1'b0, 1'b0, 6'b000010, 0, 5, 102);
    // R9 with same-cycle takeover: shadow still records ch2 (R7)
    step(6'b000011, 1'b1, 1'b1, 1'b1, 6'b000001, 2, 7, 103);
    step(6'b000010, 1'b1, 1'b1, 1'b0, 6'b000010, 0, 8, 104);
    step(6'b000000, 1'b1, 1'b0, 1'b0, 6'b000000, 0, 4, 105);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule